// File: doc/BRIEF.md
# Packed Widening Multiply-Add Unit

This block is a SIMD integer multiply stage for a 128-bit vector datapath. It takes two source vectors and a 3-bit opcode. It returns one registered result vector, one cycle after a valid strobe. Each opcode picks how the operand vectors are split into lanes and how the lane products are combined.

Two opcodes widen the products and then add each adjacent pair horizontally into a lane twice as wide:
- 16-bit signed by signed, giving 32-bit lanes.
- 8-bit unsigned by signed, giving 16-bit lanes that saturate.

Three opcodes keep 16-bit lanes and return one half of each product. Two opcodes multiply only the even 32-bit lanes into full 64-bit results. There is no accumulator operand. Any accumulation is left to a later stage.

The result register loads only on a valid cycle and otherwise keeps its last value.

Top module: `pmadd_unit`

## Requirements
- R1: While reset is asserted (rstN low), validOut is 0 and result is all zeros.
- R2: validOut equals the value validIn had at the previous rising clock edge.
- R3: Opcode 0 (pair16) works on 16-bit lanes, where lane k is opA/opB bits [16k+15:16k].
  - Result bits [32i+31:32i] = a[2i]*b[2i] + a[2i+1]*b[2i+1], with all values signed, taken modulo 2^32.
  - When all four inputs are 0x8000, the lane is 0x80000000.
- R4: Opcode 1 (pair8) works on byte lanes, where byte k is bits [8k+7:8k].
  - Bytes of opA are unsigned and bytes of opB are signed.
  - Result bits [16i+15:16i] = ua[2i]*sb[2i] + ua[2i+1]*sb[2i+1], saturated to the range -32768..32767.
- R5: Opcode 2 (mullo16) gives, for each 16-bit lane, the low 16 bits of a[k]*b[k], placed at bits [16k+15:16k].
- R6: Opcode 3 (mulhi16s) gives, for each 16-bit lane, bits [31:16] of the signed 32-bit product a[k]*b[k].
- R7: Opcode 4 (mulhi16u) gives, for each 16-bit lane, bits [31:16] of the unsigned 32-bit product a[k]*b[k].
- R8: Opcode 5 (mul32s) multiplies 32-bit lanes 0 and 2 (bits [31:0] and [95:64]) as signed values.
  - The 64-bit products go to result bits [63:0] and [127:64].
  - The odd 32-bit lanes have no effect on the result.
- R9: Opcode 6 (mul32u) is the same as R8, with unsigned operands.
- R10: Opcode 7 is reserved. It gives an all-zero result, and validOut is still asserted.
- R11: On a cycle with validIn low, result keeps its previous value whatever opA, opB and opcode are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 3 | Operation select, encoding as in R3 to R10 |
| opA | input | 128 | First source vector |
| opB | input | 128 | Second source vector |
| validOut | output | 1 | Result register was loaded on the last edge |
| result | output | 128 | Registered result vector |

## Verification
Every opcode's result is due at the first rising edge after the valid input. validOut rises at that same edge.

The bench drives inputs at the falling edge. At the next falling edge it compares validOut and result against the expected values. Its behavioural model computed those values when the inputs were applied and stored them for exactly one cycle.

When the strobe is low, the stored expectation stays unchanged. The hold behaviour is therefore compared with the value from the last valid operation, while the bench changes the operands and opcode.

Directed corner vectors cover:
- pair16 overflow;
- both saturation limits of pair8;
- extreme high-half products;
- the reserved opcode.

Random traffic with gaps in the strobe follows the directed vectors.

// File: rtl/pmadd_pkg.sv
package pmadd_pkg;

  typedef enum logic [2:0] {
    OP_PAIR16  = 3'd0,
    OP_PAIR8   = 3'd1,
    OP_LO16    = 3'd2,
    OP_HI16S   = 3'd3,
    OP_HI16U   = 3'd4,
    OP_MUL32S  = 3'd5,
    OP_MUL32U  = 3'd6,
    OP_RSVD    = 3'd7
  } opcode_e;

  typedef struct packed {
    logic load;
    logic pair16;
    logic pair8;
    logic lo16;
    logic hi16s;
    logic hi16u;
    logic mul32s;
    logic mul32u;
  } strobe_t;

endpackage

// File: rtl/pmadd_ctrl.sv
module pmadd_ctrl
  import pmadd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [2:0] opcode,
  output strobe_t    stb,
  output logic       validOut
);

  always_comb begin
    stb        = '0;
    stb.load   = validIn;
    unique case (opcode_e'(opcode))
      OP_PAIR16: stb.pair16 = 1'b1;
      OP_PAIR8:  stb.pair8  = 1'b1;
      OP_LO16:   stb.lo16   = 1'b1;
      OP_HI16S:  stb.hi16s  = 1'b1;
      OP_HI16U:  stb.hi16u  = 1'b1;
      OP_MUL32S: stb.mul32s = 1'b1;
      OP_MUL32U: stb.mul32u = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    validOut == $past(validIn)) else $error("valid delay");  // R2

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.pair16, stb.pair8, stb.lo16, stb.hi16s, stb.hi16u,
              stb.mul32s, stb.mul32u})) else $error("select overlap");  // R10

endmodule

// File: rtl/pmadd_dpath.sv
module pmadd_dpath
  import pmadd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] result
);

  localparam int N16  = VEC_W / 16;
  localparam int NP16 = N16 / 2;
  localparam int NP8  = VEC_W / 16;
  localparam int N64  = VEC_W / 64;

  logic [VEC_W-1:0] resPair16, resPair8, resLo, resHiS, resHiU, resM32s, resM32u;
  logic [31:0]      prodS [N16];
  logic [VEC_W-1:0] nextRes;

  for (genvar k = 0; k < N16; k++) begin : g_lane16
    logic [15:0] a16, b16;
    logic [31:0] prodU;
    assign a16      = opA[16*k +: 16];
    assign b16      = opB[16*k +: 16];
    assign prodS[k] = $signed({{16{a16[15]}}, a16}) * $signed({{16{b16[15]}}, b16});
    assign prodU    = {16'b0, a16} * {16'b0, b16};
    assign resLo[16*k +: 16]  = prodS[k][15:0];
    assign resHiS[16*k +: 16] = prodS[k][31:16];
    assign resHiU[16*k +: 16] = prodU[31:16];
  end

  for (genvar p = 0; p < NP16; p++) begin : g_pair16
    assign resPair16[32*p +: 32] = prodS[2*p] + prodS[2*p+1];
  end

  for (genvar p = 0; p < NP8; p++) begin : g_pair8
    logic [7:0]         ua0, ua1, sb0, sb1;
    logic signed [17:0] m0, m1, sum;
    assign ua0 = opA[16*p +: 8];
    assign ua1 = opA[16*p+8 +: 8];
    assign sb0 = opB[16*p +: 8];
    assign sb1 = opB[16*p+8 +: 8];
    assign m0  = $signed({10'b0, ua0}) * $signed({{10{sb0[7]}}, sb0});
    assign m1  = $signed({10'b0, ua1}) * $signed({{10{sb1[7]}}, sb1});
    assign sum = m0 + m1;
    always_comb begin
      if (sum > 18'sd32767)        resPair8[16*p +: 16] = 16'h7FFF;
      else if (sum < -18'sd32768)  resPair8[16*p +: 16] = 16'h8000;
      else                         resPair8[16*p +: 16] = sum[15:0];
    end
  end

  for (genvar q = 0; q < N64; q++) begin : g_mul32
    logic [31:0] a32, b32;
    assign a32 = opA[64*q +: 32];
    assign b32 = opB[64*q +: 32];
    assign resM32s[64*q +: 64] = $signed({{32{a32[31]}}, a32}) * $signed({{32{b32[31]}}, b32});
    assign resM32u[64*q +: 64] = {32'b0, a32} * {32'b0, b32};
  end

  always_comb begin
    nextRes = '0;
    if (stb.pair16) nextRes = resPair16;
    if (stb.pair8)  nextRes = resPair8;
    if (stb.lo16)   nextRes = resLo;
    if (stb.hi16s)  nextRes = resHiS;
    if (stb.hi16u)  nextRes = resHiU;
    if (stb.mul32s) nextRes = resM32s;
    if (stb.mul32u) nextRes = resM32u;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         result <= '0;
    else if (stb.load) result <= nextRes;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.load) |-> $stable(result)) else $error("hold");  // R11

  AST_PAIR16_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.load && stb.pair16 && opA[31:0] == 32'h80008000 && opB[31:0] == 32'h80008000)
    |-> result[31:0] == 32'h80000000) else $error("pair16 wrap");  // R3

  AST_PAIR8_SAT: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.load && stb.pair8 && opA[15:0] == 16'hFFFF && opB[15:0] == 16'h7F7F)
    |-> result[15:0] == 16'h7FFF) else $error("pair8 saturate");  // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.load && !(stb.pair16 || stb.pair8 || stb.lo16 || stb.hi16s ||
                        stb.hi16u || stb.mul32s || stb.mul32u))
    |-> result == '0) else $error("reserved op");  // R10

endmodule

// File: rtl/pmadd_unit.sv
module pmadd_unit
  import pmadd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [2:0]       opcode,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic             validOut,
  output logic [VEC_W-1:0] result
);

  strobe_t stb;

  pmadd_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .opcode   (opcode),
    .stb      (stb),
    .validOut (validOut)
  );

  pmadd_dpath #(.VEC_W(VEC_W)) i_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: tb/test_pmadd_unit.sv
module test_pmadd_unit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic [2:0]   opcode = 3'd0;
  logic [127:0] opA = '0, opB = '0;
  logic         validOut;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic         expValid = 1'b0;
  logic [127:0] expRes = '0;
  logic [2:0]   expOp = 3'd0;

  always #5 clk = ~clk;

  pmadd_unit i_pmadd_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opcode(opcode),
    .opA(opA), .opB(opB), .validOut(validOut), .result(result)
  );

  function automatic longint s16(logic [127:0] v, int k);
    logic signed [15:0] t = v[16*k +: 16];
    return longint'(t);
  endfunction
  function automatic longint u16(logic [127:0] v, int k);
    logic [15:0] t = v[16*k +: 16];
    return longint'(t);
  endfunction
  function automatic int s8(logic [127:0] v, int k);
    logic signed [7:0] t = v[8*k +: 8];
    return int'(t);
  endfunction
  function automatic int u8(logic [127:0] v, int k);
    logic [7:0] t = v[8*k +: 8];
    return int'(t);
  endfunction
  function automatic longint s32(logic [127:0] v, int k);
    logic signed [31:0] t = v[32*k +: 32];
    return longint'(t);
  endfunction
  function automatic longint u32(logic [127:0] v, int k);
    logic [31:0] t = v[32*k +: 32];
    return longint'(t);
  endfunction

  function automatic logic [127:0] model(logic [2:0] op, logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    longint p;
    int s;
    case (op)
      3'd0: for (int i = 0; i < 4; i++) begin
              p = s16(a, 2*i) * s16(b, 2*i) + s16(a, 2*i+1) * s16(b, 2*i+1);
              r[32*i +: 32] = p[31:0];
            end
      3'd1: for (int i = 0; i < 8; i++) begin
              s = u8(a, 2*i) * s8(b, 2*i) + u8(a, 2*i+1) * s8(b, 2*i+1);
              if (s > 32767) s = 32767;
              if (s < -32768) s = -32768;
              r[16*i +: 16] = s[15:0];
            end
      3'd2: for (int i = 0; i < 8; i++) begin
              p = s16(a, i) * s16(b, i);
              r[16*i +: 16] = p[15:0];
            end
      3'd3: for (int i = 0; i < 8; i++) begin
              p = s16(a, i) * s16(b, i);
              r[16*i +: 16] = p[31:16];
            end
      3'd4: for (int i = 0; i < 8; i++) begin
              p = u16(a, i) * u16(b, i);
              r[16*i +: 16] = p[31:16];
            end
      3'd5: for (int i = 0; i < 2; i++) begin
              p = s32(a, 2*i) * s32(b, 2*i);
              r[64*i +: 64] = p;
            end
      3'd6: for (int i = 0; i < 2; i++) begin
              p = u32(a, 2*i) * u32(b, 2*i);
              r[64*i +: 64] = p;
            end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tagOf(logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic checkVal(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    checkVal("R2", "validOut", {127'b0, validOut}, {127'b0, expValid});
    if (expValid) checkVal(tagOf(expOp), "result", result, expRes);
    else          checkVal("R11", "held result", result, expRes);
  endtask

  task automatic step(logic v, logic [2:0] op, logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    checkOutputs();
    validIn = v; opcode = op; opA = a; opB = b;
    expValid = v;
    if (v) begin
      expRes = model(op, a, b);
      expOp  = op;
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (3) begin
      @(negedge clk);
      checkVal("R1", "reset validOut", {127'b0, validOut}, '0);
      checkVal("R1", "reset result", result, '0);
    end
    rstN = 1'b1;
    // R3 overflow corner and ordinary pair sums
    step(1, 3'd0, {4{32'h80008000}}, {4{32'h80008000}});
    step(1, 3'd0, {32'h7FFF7FFF, 32'hFFFF0001, 32'h00020003, 32'h8000FFFF},
                  {32'h7FFF8000, 32'hFFFFFFFF, 32'h00050007, 32'h7FFF0001});
    // R4 saturation at both limits
    step(1, 3'd1, {8{16'hFFFF}}, {8{16'h7F7F}});
    step(1, 3'd1, {8{16'hFFFF}}, {8{16'h8080}});
    step(1, 3'd1, {8{16'h0203}}, {8{16'hFF05}});
    // R5..R7 extremes
    step(1, 3'd2, {8{16'hFFFF}}, {8{16'h8001}});
    step(1, 3'd3, {4{32'h8000FFFF}}, {4{32'h8000FFFF}});
    step(1, 3'd4, {8{16'hFFFF}}, {8{16'hFFFF}});
    // R8, R9 with odd lanes varying (ignored)
    step(1, 3'd5, {32'hDEADBEEF, 32'h80000000, 32'h12345678, 32'hFFFFFFFF},
                  {32'hCAFEF00D, 32'h80000000, 32'h0BADF00D, 32'h00000002});
    step(1, 3'd6, {32'h11111111, 32'hFFFFFFFF, 32'h22222222, 32'h80000000},
                  {32'h33333333, 32'hFFFFFFFF, 32'h44444444, 32'h00000003});
    // R10 reserved
    step(1, 3'd7, rnd128(), rnd128());
    // R11 idle with changing inputs
    step(1, 3'd3, rnd128(), rnd128());
    step(0, 3'd0, rnd128(), rnd128());
    step(0, 3'd5, rnd128(), rnd128());
    for (int n = 0; n < 400; n++)
      step(($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), rnd128(), rnd128());
    step(0, 3'd0, '0, '0);
    step(0, 3'd0, '0, '0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule